// File: doc/BRIEF.md
# Pipeline Hazard Stall and Forward Controller

This block is the hazard-control unit of a five-stage in-order pipeline whose stages run fetch, decode, execute, memory, writeback. In every cycle it compares the two source register numbers of the instruction in decode against the destination register and write-enable of the instructions in execute, memory and writeback. From those comparisons, and from the branch-taken flag that execute raises, it decides whether fetch and decode must hold, whether execute takes a no-op bubble, whether fetch and decode are flushed, and whether each execute operand takes the writeback bypass instead of the register-file value.

The pipeline it serves has two restrictions. A register-file read cannot observe a value written in the same cycle. The only bypass carries the writeback result into the execute operand inputs in the cycle after writeback. Decode therefore holds while a matching producer sits in execute or memory. It releases once the producer reaches writeback. The forward select, computed at that moment, is registered together with the operand as the consumer moves into execute. An instruction that depends on the one just ahead of it goes F D X X E M W: two stall cycles.

Top module: `hazard_unit`

## Requirements
- R1: A source that matches the destination of the instruction directly ahead holds decode for exactly two cycles: the consumer enters execute three cycles after its producer does, and the operand selects the writeback bypass (fwd = 1) while the consumer is in execute.
- R2: A source that matches the destination of the instruction two ahead holds decode for one cycle (execute entry three cycles after the producer's) and then selects the writeback bypass.
- R3: A source that matches the destination of the instruction three ahead causes no stall (execute entry three cycles after the producer's) and selects the writeback bypass, which replaces the stale register-file read.
- R4: A source that matches only an instruction four or more ahead causes no stall and no bypass (fwd = 0), because the register file already holds the value.
- R5: Register number 0, and any producer whose write-enable is 0, never cause a stall or a bypass.
- R6: While a stall is requested, stall_fd = 1 and bubble_ex = 1. The bubble placed in execute never carries a bypass select in the following cycle.
- R7: When ex_br_taken = 1, flush_fd = 1 and bubble_ex = 1, and stall_fd = 0 even if the decode instruction would otherwise stall. No bypass select is registered into execute in the next cycle.
- R8: When the memory-stage and writeback-stage producers both match a source, the younger one (memory) governs: decode stalls, and the older writeback value is not forwarded.
- R9: The two execute operands are selected independently: one operand can take the bypass while the other reads the register file.
- R10: After synchronous reset with idle inputs, stall_fd, flush_fd, bubble_ex, fwd_a and fwd_b are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dec_src_a | input | 5 | First source register of the decode instruction |
| dec_src_b | input | 5 | Second source register of the decode instruction |
| ex_dst | input | 5 | Destination register of the execute instruction |
| ex_wen | input | 1 | Execute instruction writes its destination |
| mem_dst | input | 5 | Destination register of the memory instruction |
| mem_wen | input | 1 | Memory instruction writes its destination |
| wb_dst | input | 5 | Destination register of the writeback instruction |
| wb_wen | input | 1 | Writeback instruction writes its destination |
| ex_br_taken | input | 1 | Branch in execute is taken |
| stall_fd | output | 1 | Hold the fetch and decode pipeline registers |
| flush_fd | output | 1 | Turn the fetch and decode contents into no-ops |
| bubble_ex | output | 1 | Load a no-op into execute instead of the decode instruction |
| fwd_a | output | 1 | Execute operand A takes the writeback bypass (registered) |
| fwd_b | output | 1 | Execute operand B takes the writeback bypass (registered) |

## Verification
The bench drives the block from a small pipeline model and measures the execute-entry distance for producer/consumer gaps of one to four instructions. A stall released one cycle early or held one cycle too long shows up directly as a wrong distance, and a missing bypass at gap three shows up as fwd = 0. Directed cycles cover the cases where a wrong priority is visible. With memory and writeback both matching, a design that forwards the older value does not stall. With a branch taken over a stalling decode, a design that lets the stall win holds stale instructions instead of flushing them. A bubble that keeps the bypass select leaves fwd high on a no-op. A register-0 or write-disabled producer that is not filtered creates spurious stalls.

// File: rtl/hz_pkg.sv
package hz_pkg;

    // Register index width and number of decode source operands.
    localparam int REG_BITS = 5;
    localparam int NUM_SRC  = 2;

    typedef logic [REG_BITS-1:0] reg_idx_t;

    // One in-flight instruction that may write a register.
    typedef struct packed {
        reg_idx_t dst;
        logic     wen;
    } producer_t;

    // Where a single source operand finds a pending writer.
    typedef struct packed {
        logic ex;
        logic mem;
        logic wb;
    } src_hit_t;

    // A producer only counts when it writes a register other than zero.
    function automatic logic produces_for(input reg_idx_t src, input producer_t p);
        return p.wen && (p.dst != '0) && (p.dst == src);
    endfunction

endpackage

// File: rtl/hz_src_match.sv
module hz_src_match
    import hz_pkg::*;
(
    input  reg_idx_t  src,
    input  producer_t ex_p,
    input  producer_t mem_p,
    input  producer_t wb_p,
    output src_hit_t  hit
);

    always_comb begin
        hit.ex  = produces_for(src, ex_p);
        hit.mem = produces_for(src, mem_p);
        hit.wb  = produces_for(src, wb_p);
    end

endmodule

// File: rtl/hz_ctrl.sv
module hz_ctrl
    import hz_pkg::*;
#(
    parameter int N_SRC = NUM_SRC
) (
    input  src_hit_t [N_SRC-1:0] hits,
    input  logic                 br_taken,
    output logic                 stall_fd,
    output logic                 flush_fd,
    output logic                 bubble_ex
);

    logic stall_req;

    // Decode waits while any source is pending in execute or memory;
    // a writeback-only match is served by the bypass instead.
    always_comb begin
        stall_req = 1'b0;
        for (int i = 0; i < N_SRC; i++) begin
            stall_req = stall_req | hits[i].ex | hits[i].mem;
        end
    end

    // A taken branch removes the decode instruction, so its stall request dies.
    assign flush_fd  = br_taken;
    assign stall_fd  = stall_req & ~br_taken;
    assign bubble_ex = stall_req | br_taken;

endmodule

// File: rtl/hz_fwd_reg.sv
module hz_fwd_reg
    import hz_pkg::*;
#(
    parameter int N_SRC = NUM_SRC
) (
    input  logic                 clk,
    input  logic                 rst,
    input  src_hit_t [N_SRC-1:0] hits,
    input  logic                 bubble_ex,
    output logic [N_SRC-1:0]     fwd_q
);

    // One select flop per operand, loaded as the decode instruction
    // moves into execute; a bubble carries no select.
    for (genvar g = 0; g < N_SRC; g++) begin : g_sel
        always_ff @(posedge clk) begin
            if (rst || bubble_ex) begin
                fwd_q[g] <= 1'b0;
            end else begin
                fwd_q[g] <= hits[g].wb;
            end
        end
    end

endmodule

// File: rtl/hazard_unit.sv
module hazard_unit
    import hz_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [REG_BITS-1:0] dec_src_a,
    input  logic [REG_BITS-1:0] dec_src_b,
    input  logic [REG_BITS-1:0] ex_dst,
    input  logic                ex_wen,
    input  logic [REG_BITS-1:0] mem_dst,
    input  logic                mem_wen,
    input  logic [REG_BITS-1:0] wb_dst,
    input  logic                wb_wen,
    input  logic                ex_br_taken,
    output logic                stall_fd,
    output logic                flush_fd,
    output logic                bubble_ex,
    output logic                fwd_a,
    output logic                fwd_b
);

    producer_t                  ex_p, mem_p, wb_p;
    reg_idx_t [NUM_SRC-1:0]     srcs;
    src_hit_t [NUM_SRC-1:0]     hits;
    logic     [NUM_SRC-1:0]     fwd_q;

    assign ex_p  = '{dst: ex_dst,  wen: ex_wen};
    assign mem_p = '{dst: mem_dst, wen: mem_wen};
    assign wb_p  = '{dst: wb_dst,  wen: wb_wen};
    assign srcs  = {dec_src_b, dec_src_a};

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        hz_src_match u_match (
            .src   (srcs[g]),
            .ex_p  (ex_p),
            .mem_p (mem_p),
            .wb_p  (wb_p),
            .hit   (hits[g])
        );
    end

    hz_ctrl #(.N_SRC(NUM_SRC)) u_ctrl (
        .hits      (hits),
        .br_taken  (ex_br_taken),
        .stall_fd  (stall_fd),
        .flush_fd  (flush_fd),
        .bubble_ex (bubble_ex)
    );

    hz_fwd_reg #(.N_SRC(NUM_SRC)) u_fwd (
        .clk       (clk),
        .rst       (rst),
        .hits      (hits),
        .bubble_ex (bubble_ex),
        .fwd_q     (fwd_q)
    );

    assign fwd_a = fwd_q[0];
    assign fwd_b = fwd_q[1];

endmodule

// File: rtl/hazard_unit_chk.sv
module hazard_unit_chk
    import hz_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic [REG_BITS-1:0] dec_src_a,
    input logic [REG_BITS-1:0] dec_src_b,
    input logic [REG_BITS-1:0] ex_dst,
    input logic                ex_wen,
    input logic [REG_BITS-1:0] wb_dst,
    input logic                wb_wen,
    input logic                ex_br_taken,
    input logic                stall_fd,
    input logic                flush_fd,
    input logic                bubble_ex,
    input logic                fwd_a,
    input logic                fwd_b
);

    // R1: an execute-stage writer of a decode source holds decode
    p_ex_match_stalls_r1: assert property (@(posedge clk) disable iff (rst)
        (ex_wen && ex_dst != '0 && ex_dst == dec_src_a && !ex_br_taken) |-> stall_fd);

    // R3: a bypass select implies a writeback match one cycle earlier
    p_fwd_from_wb_r3: assert property (@(posedge clk) disable iff (rst)
        fwd_a |-> ($past(wb_wen) && $past(wb_dst) == $past(dec_src_a) && $past(dec_src_a) != '0));

    // R5: sources of register zero never stall
    p_zero_no_stall_r5: assert property (@(posedge clk) disable iff (rst)
        (dec_src_a == '0 && dec_src_b == '0) |-> !stall_fd);

    // R6: a stall always comes with a bubble into execute
    p_stall_bubble_r6: assert property (@(posedge clk) disable iff (rst)
        stall_fd |-> bubble_ex);

    // R6: the bubble never carries a bypass select
    p_bubble_no_fwd_r6: assert property (@(posedge clk) disable iff (rst)
        bubble_ex |=> (!fwd_a && !fwd_b));

    // R7: a taken branch flushes and overrides any stall
    p_flush_wins_r7: assert property (@(posedge clk) disable iff (rst)
        ex_br_taken |-> (flush_fd && bubble_ex && !stall_fd));

endmodule

bind hazard_unit hazard_unit_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .dec_src_a   (dec_src_a),
    .dec_src_b   (dec_src_b),
    .ex_dst      (ex_dst),
    .ex_wen      (ex_wen),
    .wb_dst      (wb_dst),
    .wb_wen      (wb_wen),
    .ex_br_taken (ex_br_taken),
    .stall_fd    (stall_fd),
    .flush_fd    (flush_fd),
    .bubble_ex   (bubble_ex),
    .fwd_a       (fwd_a),
    .fwd_b       (fwd_b)
);

// File: tb/hazard_unit_tb.sv
`timescale 1ns/1ps
module hazard_unit_tb;

    logic       clk = 1'b0;
    logic       rst;
    logic [4:0] src_a, src_b, exd, memd, wbd;
    logic       exw, memw, wbw, br;
    logic       stall_fd, flush_fd, bubble_ex, fwd_a, fwd_b;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;   // 50 MHz

    hazard_unit u_dut (
        .clk(clk), .rst(rst),
        .dec_src_a(src_a), .dec_src_b(src_b),
        .ex_dst(exd), .ex_wen(exw),
        .mem_dst(memd), .mem_wen(memw),
        .wb_dst(wbd), .wb_wen(wbw),
        .ex_br_taken(br),
        .stall_fd(stall_fd), .flush_fd(flush_fd), .bubble_ex(bubble_ex),
        .fwd_a(fwd_a), .fwd_b(fwd_b)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic chk_eq(input string req, input int act, input int exp);
        check(act == exp, req, act, exp);
    endtask

    // ---------------- behavioural pipeline model ----------------
    logic [4:0] p_dst[8], p_a[8], p_b[8];
    logic       p_wen[8];
    int         e_cyc[8];
    logic       e_fa[8], e_fb[8];
    int         f_i, d_i, e_i, m_i, w_i, pc, cyc, n_ins;

    task automatic clear_prog();
        for (int i = 0; i < 8; i++) begin
            p_dst[i] = '0; p_a[i] = '0; p_b[i] = '0; p_wen[i] = 1'b0;
            e_cyc[i] = -100; e_fa[i] = 1'b0; e_fb[i] = 1'b0;
        end
    endtask

    task automatic idle_inputs();
        src_a = '0; src_b = '0; exd = '0; memd = '0; wbd = '0;
        exw = 0; memw = 0; wbw = 0; br = 0;
    endtask

    task automatic drive_model();
        src_a = (d_i >= 0) ? p_a[d_i]   : 5'd0;
        src_b = (d_i >= 0) ? p_b[d_i]   : 5'd0;
        exd   = (e_i >= 0) ? p_dst[e_i] : 5'd0;
        exw   = (e_i >= 0) ? p_wen[e_i] : 1'b0;
        memd  = (m_i >= 0) ? p_dst[m_i] : 5'd0;
        memw  = (m_i >= 0) ? p_wen[m_i] : 1'b0;
        wbd   = (w_i >= 0) ? p_dst[w_i] : 5'd0;
        wbw   = (w_i >= 0) ? p_wen[w_i] : 1'b0;
        br    = 1'b0;
    endtask

    task automatic run_prog(input int n);
        logic st;
        n_ins = n;
        f_i = 0; d_i = -1; e_i = -1; m_i = -1; w_i = -1; pc = 1; cyc = 0;
        drive_model();
        for (int c = 0; c < 16; c++) begin
            @(negedge clk);
            #1;
            st = stall_fd;
            if (e_i >= 0) begin e_fa[e_i] = fwd_a; e_fb[e_i] = fwd_b; end
            @(posedge clk);
            #1;
            cyc++;
            w_i = m_i;
            m_i = e_i;
            e_i = st ? -1 : d_i;
            if (e_i >= 0) e_cyc[e_i] = cyc;
            if (!st) begin
                d_i = f_i;
                f_i = (pc < n_ins) ? pc : -1;
                if (pc < n_ins) pc++;
            end
            drive_model();
        end
        idle_inputs();
        @(posedge clk);
        #1;
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        idle_inputs();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        chk_eq("R10 stall_fd", stall_fd, 0);
        chk_eq("R10 flush_fd", flush_fd, 0);
        chk_eq("R10 bubble_ex", bubble_ex, 0);
        chk_eq("R10 fwd_a", fwd_a, 0);
        chk_eq("R10 fwd_b", fwd_b, 0);
    endtask

    task automatic t_back_to_back();
        clear_prog();
        p_dst[0] = 5'd3; p_wen[0] = 1;
        p_a[1] = 5'd3;
        run_prog(2);
        chk_eq("R1 execute entry gap", e_cyc[1] - e_cyc[0], 3);
        chk_eq("R1 fwd_a in execute", e_fa[1], 1);
    endtask

    task automatic t_two_ahead();
        clear_prog();
        p_dst[0] = 5'd4; p_wen[0] = 1;
        p_b[2] = 5'd4;
        run_prog(3);
        chk_eq("R2 execute entry gap", e_cyc[2] - e_cyc[0], 3);
        chk_eq("R2 fwd_b in execute", e_fb[2], 1);
    endtask

    task automatic t_three_ahead();
        clear_prog();
        p_dst[0] = 5'd9; p_wen[0] = 1;
        p_a[3] = 5'd9;
        run_prog(4);
        chk_eq("R3 execute entry gap", e_cyc[3] - e_cyc[0], 3);
        chk_eq("R3 fwd_a in execute", e_fa[3], 1);
    endtask

    task automatic t_four_ahead();
        clear_prog();
        p_dst[0] = 5'd11; p_wen[0] = 1;
        p_a[4] = 5'd11;
        run_prog(5);
        chk_eq("R4 execute entry gap", e_cyc[4] - e_cyc[0], 4);
        chk_eq("R4 fwd_a in execute", e_fa[4], 0);
    endtask

    task automatic t_zero_and_wen();
        clear_prog();
        p_dst[0] = 5'd0; p_wen[0] = 1;
        p_a[1] = 5'd0;
        p_dst[2] = 5'd5; p_wen[2] = 0;
        p_b[3] = 5'd5;
        run_prog(4);
        chk_eq("R5 reg0 execute gap", e_cyc[1] - e_cyc[0], 1);
        chk_eq("R5 reg0 fwd_a", e_fa[1], 0);
        chk_eq("R5 wen low execute gap", e_cyc[3] - e_cyc[2], 1);
        chk_eq("R5 wen low fwd_b", e_fb[3], 0);
    endtask

    task automatic t_two_operands();
        clear_prog();
        p_dst[0] = 5'd6; p_wen[0] = 1;
        p_dst[1] = 5'd7; p_wen[1] = 1;
        p_a[2] = 5'd7; p_b[2] = 5'd6;
        run_prog(3);
        chk_eq("R9 execute entry gap", e_cyc[2] - e_cyc[1], 3);
        chk_eq("R9 fwd_a bypass", e_fa[2], 1);
        chk_eq("R9 fwd_b register file", e_fb[2], 0);
    endtask

    task automatic t_youngest();
        idle_inputs();
        src_a = 5'd8; memd = 5'd8; memw = 1; wbd = 5'd8; wbw = 1;
        #1;
        chk_eq("R8 stall on younger match", stall_fd, 1);
        @(posedge clk);
        #1;
        chk_eq("R8 older value not forwarded", fwd_a, 0);
        idle_inputs();
    endtask

    task automatic t_stall_bubble();
        idle_inputs();
        src_b = 5'd12; exd = 5'd12; exw = 1; wbd = 5'd12; wbw = 1;
        #1;
        chk_eq("R6 stall_fd", stall_fd, 1);
        chk_eq("R6 bubble_ex", bubble_ex, 1);
        @(posedge clk);
        #1;
        chk_eq("R6 bubble carries no fwd_b", fwd_b, 0);
        idle_inputs();
    endtask

    task automatic t_branch();
        idle_inputs();
        src_a = 5'd13; exd = 5'd13; exw = 1;
        src_b = 5'd14; wbd = 5'd14; wbw = 1;
        br = 1;
        #1;
        chk_eq("R7 flush_fd", flush_fd, 1);
        chk_eq("R7 bubble_ex", bubble_ex, 1);
        chk_eq("R7 stall_fd suppressed", stall_fd, 0);
        @(posedge clk);
        #1;
        chk_eq("R7 no fwd_b after flush", fwd_b, 0);
        idle_inputs();
        #1;
        chk_eq("R7 flush_fd drops", flush_fd, 0);
    endtask

    initial begin
        t_reset();
        t_back_to_back();
        t_two_ahead();
        t_three_ahead();
        t_four_ahead();
        t_zero_and_wen();
        t_two_operands();
        t_youngest();
        t_stall_bubble();
        t_branch();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 5000, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule